// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

This block is a memory with one write port and one read port that view the same bit storage at two different word widths. A narrow port sees more, smaller words and a wide port sees fewer, larger words; for example a 4-bit write port can fill a memory that is read back 16 bits at a time, or the reverse. Each side runs on its own clock, with its own clock enable and its own asynchronous clear.

Writes are synchronous to the write clock. The read address is captured in a register when a read is requested. A parameter chooses whether the read word leaves through a combinational path or through an output register, which adds one read-clock cycle of latency and gives a fully pipelined memory.

A second parameter selects single-port operation. In that mode one address serves both reads and writes, and the read-address register follows every write, so the word just written appears at the output with no extra request.

Top module: `mixw_sdp_ram`

## Requirements
- R1: The write port holds WR_W bits per word and the read port holds RD_W bits per word over MEM_BITS shared bits. Word n of a port occupies storage bits n*W to n*W+W-1, so the narrow word with the lowest index inside a wide word lands in that wide word's least significant bits.
- R2: A write takes place at a rising wr_clk edge where wr_ce and wr_en are 1 and wr_aclr is 0. With wr_ce at 0 nothing is written.
- R3: In dual-port mode rd_addr is captured at a rising rd_clk edge where rd_ce and rd_en are 1. With the output unregistered, rd_q shows the addressed word right after that edge. With the output registered, it shows it after the following edge. A write at one edge is seen by a read captured at that edge or any later edge.
- R4: With rd_en at 0 the read address is not captured, and a registered rd_q holds its value at the edge after the next one.
- R5: With rd_ce at 0 the read address is not captured and a registered rd_q holds its value.
- R6: rd_aclr at 1 forces a registered rd_q to 0 at once, without waiting for a clock edge.
- R7: wr_aclr at 1 blocks writes and clears the read-address register to 0 at once. It leaves the stored words untouched.
- R8: In single-port mode (SINGLE_PORT=1), wr_addr addresses both reads and writes and rd_addr is ignored. A write also loads the read-address register. The written word therefore shows on an unregistered rd_q right after the write edge, and on a registered rd_q after the next rd_clk edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_ce | input | 1 | Write-side clock enable |
| wr_aclr | input | 1 | Write-side asynchronous clear, active high |
| wr_en | input | 1 | Write request |
| wr_addr | input | WA_W | Write address; also the read address in single-port mode |
| wr_data | input | WR_W | Write word |
| rd_clk | input | 1 | Read-side clock |
| rd_ce | input | 1 | Read-side clock enable |
| rd_aclr | input | 1 | Read-side asynchronous clear of the output register, active high |
| rd_en | input | 1 | Read request |
| rd_addr | input | RA_W | Read address (dual-port mode) |
| rd_q | output | RD_W | Read word |

## Verification
The bench drives four instances from one clock: narrow-write/wide-read with a registered output, wide-write/narrow-read with an unregistered output, and both output settings in single-port mode. A reference bit array predicts every read.

The bench targets these corner cases:
- Slice order within a wide word is checked against a literal value. A design with the slices reversed would return nibbles or bytes in swapped positions.
- Reads are captured one cycle after a write, and at the same edge as a write. A design that reads the array before the write lands would return stale data.
- Writes, rd_en low and rd_ce low are mixed with held outputs. A design that ignores either enable would show a moved address or a reloaded register.
- The asynchronous clears are sampled between clock edges. This catches clears that are actually synchronous, and a write clear that wipes or alters the contents.

// File: rtl/mixw_pkg.sv
package mixw_pkg;

    // Kind of access captured with the read address; it decides whether
    // the output register loads at the next read-clock edge.
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

endpackage

// File: rtl/mixw_store.sv
module mixw_store #(
    parameter int WR_W     = 4,
    parameter int RD_W     = 16,
    parameter int MEM_BITS = 256,
    localparam int WA_W    = $clog2(MEM_BITS / WR_W),
    localparam int RA_W    = $clog2(MEM_BITS / RD_W),
    localparam int IDX_W   = $clog2(MEM_BITS),
    localparam int WSH     = $clog2(WR_W),
    localparam int RSH     = $clog2(RD_W)
) (
    input  logic            wr_clk,
    input  logic            wr_ce,
    input  logic            wr_aclr,
    input  logic            wr_en,
    input  logic [WA_W-1:0] wr_addr,
    input  logic [WR_W-1:0] wr_data,
    input  logic [RA_W-1:0] rd_addr,
    output logic [RD_W-1:0] rd_word
);

    // One flat bit vector; each port slices it at its own width (R1).
    logic [MEM_BITS-1:0] bits_q;
    logic [IDX_W-1:0]    wbase;
    logic [IDX_W-1:0]    rbase;
    logic                wr_go;

    assign wbase = IDX_W'(wr_addr) << WSH;
    assign rbase = IDX_W'(rd_addr) << RSH;
    assign wr_go = wr_ce && wr_en && !wr_aclr;   // R2, R7: clear blocks writes

    always_ff @(posedge wr_clk) begin
        if (wr_go) begin
            bits_q[wbase +: WR_W] <= wr_data;
        end
    end

    assign rd_word = bits_q[rbase +: RD_W];

endmodule

// File: rtl/mixw_addr_cap.sv
module mixw_addr_cap
    import mixw_pkg::*;
#(
    parameter int RA_W = 4
) (
    input  logic            cap_clk,
    input  logic            cap_clr,
    input  logic            cap_ce,
    input  logic            rd_req,
    input  logic            wr_req,
    input  logic [RA_W-1:0] addr_in,
    output logic [RA_W-1:0] addr_q,
    output acc_e            acc_q
);

    logic [RA_W-1:0] addr_d;
    acc_e            acc_d;

    // Next-state logic: a write wins over a read; no request clears the kind.
    always_comb begin
        addr_d = addr_q;
        acc_d  = acc_q;
        if (cap_ce) begin
            if (wr_req) begin
                addr_d = addr_in;
                acc_d  = ACC_WRITE;
            end else if (rd_req) begin
                addr_d = addr_in;
                acc_d  = ACC_READ;
            end else begin
                acc_d  = ACC_NONE;
            end
        end
    end

    // State register; the input-side clear empties it at once (R7).
    always_ff @(posedge cap_clk or posedge cap_clr) begin
        if (cap_clr) begin
            addr_q <= '0;
            acc_q  <= ACC_NONE;
        end else begin
            addr_q <= addr_d;
            acc_q  <= acc_d;
        end
    end

endmodule

// File: rtl/mixw_out_stage.sv
module mixw_out_stage
    import mixw_pkg::*;
#(
    parameter int RD_W    = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic            rd_clk,
    input  logic            rd_ce,
    input  logic            rd_aclr,
    input  acc_e            acc,
    input  logic [RD_W-1:0] word,
    output logic [RD_W-1:0] q
);

    generate
        if (OUT_REG) begin : g_flop
            logic [RD_W-1:0] q_r;
            always_ff @(posedge rd_clk or posedge rd_aclr) begin
                if (rd_aclr) begin
                    q_r <= '0;                          // R6
                end else if (rd_ce) begin               // R5
                    unique case (acc)
                        ACC_READ, ACC_WRITE: q_r <= word;   // R3, R8
                        default:             q_r <= q_r;    // R4
                    endcase
                end
            end
            assign q = q_r;
        end else begin : g_comb
            assign q = word;
        end
    endgenerate

endmodule

// File: rtl/mixw_sdp_ram.sv
module mixw_sdp_ram
    import mixw_pkg::*;
#(
    parameter int WR_W        = 4,
    parameter int RD_W        = 16,
    parameter int MEM_BITS    = 256,
    parameter bit OUT_REG     = 1'b1,
    parameter bit SINGLE_PORT = 1'b0,
    localparam int WA_W       = $clog2(MEM_BITS / WR_W),
    localparam int RA_W       = $clog2(MEM_BITS / RD_W)
) (
    input  logic            wr_clk,
    input  logic            wr_ce,
    input  logic            wr_aclr,
    input  logic            wr_en,
    input  logic [WA_W-1:0] wr_addr,
    input  logic [WR_W-1:0] wr_data,
    input  logic            rd_clk,
    input  logic            rd_ce,
    input  logic            rd_aclr,
    input  logic            rd_en,
    input  logic [RA_W-1:0] rd_addr,
    output logic [RD_W-1:0] rd_q
);

    localparam int IDX_W = $clog2(MEM_BITS);
    localparam int WSH   = $clog2(WR_W);
    localparam int RSH   = $clog2(RD_W);

    logic            cap_clk;
    logic            cap_ce;
    logic            cap_rd;
    logic            cap_wr;
    logic [RA_W-1:0] cap_addr;
    logic [RA_W-1:0] raddr_q;
    acc_e            acc_q;
    logic [RD_W-1:0] word;

    generate
        if (SINGLE_PORT) begin : g_single
            // R8: one address, captured on the write clock for both access kinds.
            assign cap_clk  = wr_clk;
            assign cap_ce   = wr_ce;
            assign cap_rd   = rd_en;
            assign cap_wr   = wr_en;
            assign cap_addr = RA_W'((IDX_W'(wr_addr) << WSH) >> RSH);
        end else begin : g_dual
            // R3: independent read address on the read clock.
            assign cap_clk  = rd_clk;
            assign cap_ce   = rd_ce;
            assign cap_rd   = rd_en;
            assign cap_wr   = 1'b0;
            assign cap_addr = rd_addr;
        end
    endgenerate

    mixw_store #(
        .WR_W     (WR_W),
        .RD_W     (RD_W),
        .MEM_BITS (MEM_BITS)
    ) u_store (
        .wr_clk  (wr_clk),
        .wr_ce   (wr_ce),
        .wr_aclr (wr_aclr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (raddr_q),
        .rd_word (word)
    );

    mixw_addr_cap #(
        .RA_W (RA_W)
    ) u_cap (
        .cap_clk (cap_clk),
        .cap_clr (wr_aclr),
        .cap_ce  (cap_ce),
        .rd_req  (cap_rd),
        .wr_req  (cap_wr),
        .addr_in (cap_addr),
        .addr_q  (raddr_q),
        .acc_q   (acc_q)
    );

    mixw_out_stage #(
        .RD_W    (RD_W),
        .OUT_REG (OUT_REG)
    ) u_out (
        .rd_clk  (rd_clk),
        .rd_ce   (rd_ce),
        .rd_aclr (rd_aclr),
        .acc     (acc_q),
        .word    (word),
        .q       (rd_q)
    );

endmodule

// File: rtl/mixw_sdp_ram_chk.sv
module mixw_sdp_ram_chk #(
    parameter int WR_W        = 4,
    parameter int RD_W        = 16,
    parameter bit OUT_REG     = 1'b1,
    parameter bit SINGLE_PORT = 1'b0
) (
    input logic            wr_clk,
    input logic            wr_ce,
    input logic            wr_aclr,
    input logic            wr_en,
    input logic [WR_W-1:0] wr_data,
    input logic            rd_clk,
    input logic            rd_ce,
    input logic            rd_aclr,
    input logic            rd_en,
    input logic [RD_W-1:0] rd_q
);

    localparam int MINW = (WR_W < RD_W) ? WR_W : RD_W;

    // R6: while the read clear is high the registered output reads zero.
    assert_out_clear_R6: assert property (@(posedge rd_clk) disable iff (wr_aclr)
        (OUT_REG && rd_aclr) |-> (rd_q == '0));

    // R5: a disabled read clock leaves the registered output where it was.
    assert_ce_hold_R5: assert property (@(posedge rd_clk) disable iff (rd_aclr || wr_aclr)
        (OUT_REG && !rd_ce) |=> $stable(rd_q));

    // R4: no read request means no reload at the edge after the next one.
    assert_rden_hold_R4: assert property (@(posedge rd_clk) disable iff (rd_aclr || wr_aclr)
        (OUT_REG && !SINGLE_PORT && !rd_en) |-> ##2 $stable(rd_q));

    // R8: single-port, unregistered: the written word is on the output after the edge.
    assert_sp_pass_R8: assert property (@(posedge wr_clk) disable iff (wr_aclr || rd_aclr)
        (SINGLE_PORT && !OUT_REG && (WR_W == RD_W) && wr_ce && wr_en)
        |=> (rd_q[MINW-1:0] == $past(wr_data[MINW-1:0])));

endmodule

bind mixw_sdp_ram mixw_sdp_ram_chk #(
    .WR_W        (WR_W),
    .RD_W        (RD_W),
    .OUT_REG     (OUT_REG),
    .SINGLE_PORT (SINGLE_PORT)
) u_chk (
    .wr_clk  (wr_clk),
    .wr_ce   (wr_ce),
    .wr_aclr (wr_aclr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_clk  (rd_clk),
    .rd_ce   (rd_ce),
    .rd_aclr (rd_aclr),
    .rd_en   (rd_en),
    .rd_q    (rd_q)
);

// File: tb/mixw_sdp_ram_test.sv
`timescale 1ns/1ps
module mixw_sdp_ram_test;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic wr_ce, rd_ce, wr_aclr, rd_aclr;

    // A: 4-bit write, 16-bit read, registered output
    logic a_wen, a_ren; logic [5:0] a_wa; logic [3:0] a_wd; logic [3:0] a_ra; logic [15:0] a_q;
    // B: 16-bit write, 4-bit read, unregistered output
    logic b_wen, b_ren; logic [3:0] b_wa; logic [15:0] b_wd; logic [5:0] b_ra; logic [3:0] b_q;
    // S: single-port 8/8 registered; U: single-port 8/8 unregistered
    logic s_wen, s_ren; logic [4:0] s_wa; logic [7:0] s_wd; logic [7:0] s_q;
    logic u_wen, u_ren; logic [4:0] u_wa; logic [7:0] u_wd; logic [7:0] u_q;

    logic [255:0] ref_a, ref_b;
    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    mixw_sdp_ram #(.WR_W(4), .RD_W(16), .MEM_BITS(256), .OUT_REG(1'b1), .SINGLE_PORT(1'b0)) uut (
        .wr_clk(clk), .wr_ce(wr_ce), .wr_aclr(wr_aclr), .wr_en(a_wen), .wr_addr(a_wa), .wr_data(a_wd),
        .rd_clk(clk), .rd_ce(rd_ce), .rd_aclr(rd_aclr), .rd_en(a_ren), .rd_addr(a_ra), .rd_q(a_q));

    mixw_sdp_ram #(.WR_W(16), .RD_W(4), .MEM_BITS(256), .OUT_REG(1'b0), .SINGLE_PORT(1'b0)) uut_b (
        .wr_clk(clk), .wr_ce(wr_ce), .wr_aclr(wr_aclr), .wr_en(b_wen), .wr_addr(b_wa), .wr_data(b_wd),
        .rd_clk(clk), .rd_ce(rd_ce), .rd_aclr(rd_aclr), .rd_en(b_ren), .rd_addr(b_ra), .rd_q(b_q));

    mixw_sdp_ram #(.WR_W(8), .RD_W(8), .MEM_BITS(256), .OUT_REG(1'b1), .SINGLE_PORT(1'b1)) uut_s (
        .wr_clk(clk), .wr_ce(wr_ce), .wr_aclr(wr_aclr), .wr_en(s_wen), .wr_addr(s_wa), .wr_data(s_wd),
        .rd_clk(clk), .rd_ce(rd_ce), .rd_aclr(rd_aclr), .rd_en(s_ren), .rd_addr(5'd0), .rd_q(s_q));

    mixw_sdp_ram #(.WR_W(8), .RD_W(8), .MEM_BITS(256), .OUT_REG(1'b0), .SINGLE_PORT(1'b1)) uut_u (
        .wr_clk(clk), .wr_ce(wr_ce), .wr_aclr(wr_aclr), .wr_en(u_wen), .wr_addr(u_wa), .wr_data(u_wd),
        .rd_clk(clk), .rd_ce(rd_ce), .rd_aclr(rd_aclr), .rd_en(u_ren), .rd_addr(5'd0), .rd_q(u_q));

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic a_wr(input int addr, input logic [3:0] d, input bit lands);
        a_wa = 6'(addr); a_wd = d; a_wen = 1'b1;
        step();
        a_wen = 1'b0;
        if (lands) ref_a[addr*4 +: 4] = d;
    endtask

    task automatic a_rd(input int addr);   // registered: two edges
        a_ra = 4'(addr); a_ren = 1'b1;
        step();
        a_ren = 1'b0;
        step();
    endtask

    task automatic b_wr(input int addr, input logic [15:0] d);
        b_wa = 4'(addr); b_wd = d; b_wen = 1'b1;
        step();
        b_wen = 1'b0;
        ref_b[addr*16 +: 16] = d;
    endtask

    task automatic b_rd(input int addr);   // unregistered: one edge
        b_ra = 6'(addr); b_ren = 1'b1;
        step();
        b_ren = 1'b0;
    endtask

    task automatic t_reset();
        chk("R6 reset A out", a_q, 16'h0);
        chk("R6 reset S out", {8'h0, s_q}, 16'h0);
    endtask

    task automatic t_map();
        for (int i = 0; i < 16; i++) a_wr(i, 4'(i) ^ 4'h9, 1'b1);
        a_rd(0);
        chk("R1 narrow slice 0 in wide LSBs", a_q, 16'hAB89);
        for (int w = 1; w < 4; w++) begin
            a_rd(w);
            chk("R1 R3 wide read A", a_q, ref_a[w*16 +: 16]);
        end
        for (int w = 0; w < 4; w++) b_wr(w, 16'hC3A5 + 16'(w) * 16'h1111);
        b_rd(1);
        chk("R1 narrow read of wide word", {12'h0, b_q}, 16'h000A);
        for (int n = 0; n < 16; n++) begin
            b_rd(n);
            chk("R1 R3 narrow read B", {12'h0, b_q}, {12'h0, ref_b[n*4 +: 4]});
        end
    endtask

    task automatic t_back();
        a_wr(9, 4'h6, 1'b1);
        a_rd(2);
        chk("R3 A read one cycle after write", a_q, ref_a[32 +: 16]);
        // write and capture at the same edge
        a_wa = 6'd13; a_wd = 4'h2; a_wen = 1'b1; a_ra = 4'd3; a_ren = 1'b1;
        step();
        a_wen = 1'b0; a_ren = 1'b0; ref_a[52 +: 4] = 4'h2;
        step();
        chk("R3 A read captured at write edge", a_q, ref_a[48 +: 16]);
        b_wr(6, 16'h5A3C);
        b_rd(24);
        chk("R3 B read one cycle after write", {12'h0, b_q}, 16'h000C);
        b_rd(27);
        chk("R3 B read top slice", {12'h0, b_q}, 16'h0005);
    endtask

    task automatic t_rden();
        a_rd(0);
        a_ra = 4'd1; a_ren = 1'b0;
        step(); step();
        chk("R4 A holds with read enable low", a_q, ref_a[0 +: 16]);
        b_rd(3);
        b_ra = 6'd10; b_ren = 1'b0;
        step();
        chk("R4 B address not captured", {12'h0, b_q}, {12'h0, ref_b[12 +: 4]});
    endtask

    task automatic t_ce();
        logic [15:0] old;
        a_rd(1);
        old = a_q;
        rd_ce = 1'b0;
        a_ra = 4'd2; a_ren = 1'b1;
        a_wr(5, ~ref_a[20 +: 4], 1'b1);
        a_ren = 1'b1;
        step();
        chk("R5 A output held with clock enable low", a_q, old);
        rd_ce = 1'b1; a_ra = 4'd1;
        step();
        a_ren = 1'b0;
        step();
        chk("R5 R2 A resumes and sees new write", a_q, ref_a[16 +: 16]);
        b_rd(5);
        rd_ce = 1'b0; b_ra = 6'd9; b_ren = 1'b1;
        step();
        chk("R5 B address held with clock enable low", {12'h0, b_q}, {12'h0, ref_b[20 +: 4]});
        b_ren = 1'b0; rd_ce = 1'b1;
    endtask

    task automatic t_wce();
        wr_ce = 1'b0;
        a_wr(0, ~ref_a[3:0], 1'b0);
        wr_ce = 1'b1;
        a_rd(0);
        chk("R2 no write with write enable gated", a_q, ref_a[0 +: 16]);
    endtask

    task automatic t_rclr();
        a_rd(2);
        chk("R6 A loaded before clear", a_q, ref_a[32 +: 16]);
        #1 rd_aclr = 1'b1;
        #1 chk("R6 asynchronous output clear", a_q, 16'h0);
        step();
        rd_aclr = 1'b0;
        a_rd(2);
        chk("R6 A reads again after clear", a_q, ref_a[32 +: 16]);
    endtask

    task automatic t_wclr();
        b_rd(5);
        b_wa = 4'd0; b_wd = 16'hFFFF; b_wen = 1'b1;
        #1 wr_aclr = 1'b1;
        #1 chk("R7 read address cleared at once", {12'h0, b_q}, {12'h0, ref_b[3:0]});
        step();
        b_wen = 1'b0; wr_aclr = 1'b0;
        for (int n = 0; n < 4; n++) begin
            b_rd(n);
            chk("R7 contents kept and write blocked", {12'h0, b_q}, {12'h0, ref_b[n*4 +: 4]});
        end
    endtask

    task automatic t_sp();
        u_wa = 5'd3; u_wd = 8'hA5; u_wen = 1'b1;
        step();
        u_wen = 1'b0;
        chk("R8 unregistered pass-through", {8'h0, u_q}, 16'h00A5);
        s_wa = 5'd3; s_wd = 8'h5A; s_wen = 1'b1;
        step();
        s_wen = 1'b0;
        chk("R8 registered lags one edge", {8'h0, s_q}, 16'h0000);
        step();
        chk("R8 registered pass-through", {8'h0, s_q}, 16'h005A);
        s_wa = 5'd7; s_wd = 8'h3C; s_wen = 1'b1;
        step();
        s_wen = 1'b0; s_wa = 5'd3; s_ren = 1'b1;
        step();
        s_ren = 1'b0;
        step();
        chk("R8 registered read by shared address", {8'h0, s_q}, 16'h005A);
        u_wa = 5'd7; u_wd = 8'hC3; u_wen = 1'b1;
        step();
        u_wen = 1'b0; u_wa = 5'd3; u_ren = 1'b1;
        step();
        u_ren = 1'b0;
        chk("R8 unregistered read by shared address", {8'h0, u_q}, 16'h00A5);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        wr_ce = 1'b1; rd_ce = 1'b1; wr_aclr = 1'b1; rd_aclr = 1'b1;
        a_wen = 0; a_ren = 0; a_wa = 0; a_wd = 0; a_ra = 0;
        b_wen = 0; b_ren = 0; b_wa = 0; b_wd = 0; b_ra = 0;
        s_wen = 0; s_ren = 0; s_wa = 0; s_wd = 0;
        u_wen = 0; u_ren = 0; u_wa = 0; u_wd = 0;
        ref_a = '0; ref_b = '0;
        step(); step();
        t_reset();
        wr_aclr = 1'b0; rd_aclr = 1'b0;
        step();
        t_map();
        t_back();
        t_rden();
        t_ce();
        t_wce();
        t_rclr();
        t_wclr();
        t_sp();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule